// File: doc/BRIEF.md
# ADC Conversion Start and Tracking Controller

This block is the digital sequencing front end of a successive-approximation converter. Software programs it through two byte-wide registers. The channel register picks one of 32 input codes. The trigger register picks the start source and reports whether a conversion is running. The block tells the analog converter which code to sample with `conv_chan`, and it fires a one-cycle `conv_start` pulse when a conversion should begin. It then waits for the converter's one-cycle done pulse and stores the returned result.

A conversion starts in one of two ways, depending on the trigger select. In software mode, writing the channel register starts a conversion. In hardware mode, a rising edge on `hw_trig` starts one. Writing the channel register always cancels a conversion that is running. The all-ones channel code parks the module in a disabled state, in which nothing starts. The two codes just below it pick the reference inputs, and they convert like any other channel.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, the channel register (address 0) reads 0x1F, the trigger register (address 1) reads 0x00, `data_out` is 0 and `conv_start` is low.
- R2: The trigger register holds the trigger select at bit 6, where 0 means software and 1 means hardware. Its bits 5 to 0 always read 0, whatever value is written to them.
- R3: Bit 7 of the trigger register is the active flag. It reads 1 from the clock edge that starts a conversion until the conversion ends. Writing the trigger register never changes it.
- R4: In software mode, writing a non-disable code to the channel register makes `conv_start` high for one cycle at the clock edge that captures the write. At that same edge `conv_chan` takes the code and the active flag sets.
- R5: In hardware mode, a 0-to-1 transition of `hw_trig` starts a conversion at the edge that first sees it high. Holding `hw_trig` high starts nothing more. A channel register write starts nothing in this mode.
- R6: A rising edge on `hw_trig` is ignored while a conversion is active, and it is also ignored while the channel code is 0x1F.
- R7: A `conv_done` pulse during an active conversion loads `conv_result` into `data_out` and clears the active flag at the same edge. A `conv_done` pulse while idle leaves `data_out` unchanged.
- R8: Writing the channel register during a conversion aborts it, and a `conv_done` in that same cycle is discarded. In software mode a non-disable code then starts a new conversion at that edge.
- R9: Writing the code 0x1F starts nothing, clears the active flag, and drives `conv_chan` to 0x1F.
- R10: The reference codes 0x1D and 0x1E start and complete a conversion exactly as the ordinary codes 0x00 to 0x1C do.
- R11: The channel register reads back as the last written 5-bit code in bits 4 to 0, with bits 7 to 5 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 channel, 1 trigger |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| hw_trig | input | 1 | Hardware start request, acted on at its rising edge |
| conv_start | output | 1 | One-cycle pulse that begins a conversion |
| conv_chan | output | 5 | Channel code driven to the converter |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| data_out | output | 10 | Last completed result |

## Verification
The assertions assume that `conv_done` is a single-cycle pulse and that `conv_result` is stable in the cycle it is sampled. They also assume that `reg_addr` is stable while `reg_rdata` is read. The bench's converter model raises done a fixed four cycles after each start. Manual done pulses are driven for exactly one cycle. Register reads happen only at the falling edge with `reg_wr` low. Stray done pulses after aborts and disables are produced on purpose, because the design must tolerate them.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
   localparam int ACT_BIT  = 7;
   localparam int TRIG_BIT = 6;

   typedef enum logic {
      SEL_CHAN = 1'b0,
      SEL_TRIG = 1'b1
   } reg_sel_e;

   typedef enum logic {
      TRIG_SOFT = 1'b0,
      TRIG_HARD = 1'b1
   } trig_mode_e;
endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
   import adc_trig_pkg::*;
#(
   parameter int CHAN_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              active,
   output logic [CHAN_W-1:0] chan,
   output logic              trig_sel,
   output logic              wr_chan,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam logic [CHAN_W-1:0] CODE_OFF = '1;

   assign wr_chan = reg_wr && (reg_sel_e'(reg_addr) == SEL_CHAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan     <= CODE_OFF;
         trig_sel <= TRIG_SOFT;
      end else if (reg_wr) begin
         if (reg_sel_e'(reg_addr) == SEL_CHAN)
            chan <= reg_wdata[CHAN_W-1:0];
         else
            trig_sel <= reg_wdata[TRIG_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel_e'(reg_addr) == SEL_TRIG) begin
         reg_rdata[ACT_BIT]  = active;
         reg_rdata[TRIG_BIT] = trig_sel;
      end else begin
         reg_rdata[CHAN_W-1:0] = chan;
      end
   end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_in,
   output logic rise
);
   logic lvl;
   logic lvl_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = hw_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= hw_in;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign lvl = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl && !lvl_q;
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
   import adc_trig_pkg::*;
#(
   parameter int CHAN_W = 5,
   parameter int RES_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_chan,
   input  logic [CHAN_W-1:0] new_chan,
   input  logic [CHAN_W-1:0] cur_chan,
   input  logic              trig_sel,
   input  logic              hw_rise,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic              conv_start,
   output logic              active,
   output logic [RES_W-1:0]  data_out
);
   logic new_off, cur_off, nxt_start, nxt_active, take_res;

   assign new_off = &new_chan;
   assign cur_off = &cur_chan;

   always_comb begin
      if (wr_chan) begin
         nxt_start  = (trig_sel == TRIG_SOFT) && !new_off;
         nxt_active = nxt_start;
      end else begin
         nxt_start  = (trig_sel == TRIG_HARD) && hw_rise && !active && !cur_off;
         nxt_active = nxt_start || (active && !conv_done);
      end
   end

   assign take_res = active && conv_done && !wr_chan;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_start <= 1'b0;
         active     <= 1'b0;
         data_out   <= '0;
      end else begin
         conv_start <= nxt_start;
         active     <= nxt_active;
         if (take_res) data_out <= conv_result;
      end
   end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
   parameter int CHAN_W      = 5,
   parameter int DATA_W      = 8,
   parameter int RES_W       = 10,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              hw_trig,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic [RES_W-1:0]  data_out
);
   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold bits 7 and 6");
      end
      if (CHAN_W < 2 || CHAN_W > DATA_W) begin : g_bad_chan
         $error("CHAN_W out of range");
      end
      if (RES_W < 1) begin : g_bad_res
         $error("RES_W must be positive");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic conv_active;
   logic trig_sel;
   logic wr_chan;
   logic hw_rise;

   adc_trig_regs #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .active(conv_active), .chan(conv_chan),
      .trig_sel(trig_sel), .wr_chan(wr_chan), .reg_rdata(reg_rdata)
   );

   adc_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .hw_in(hw_trig), .rise(hw_rise)
   );

   adc_trig_seq #(.CHAN_W(CHAN_W), .RES_W(RES_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_chan(wr_chan),
      .new_chan(reg_wdata[CHAN_W-1:0]), .cur_chan(conv_chan),
      .trig_sel(trig_sel), .hw_rise(hw_rise), .conv_done(conv_done),
      .conv_result(conv_result), .conv_start(conv_start),
      .active(conv_active), .data_out(data_out)
   );
endmodule

// File: rtl/adc_trig_checker.sv
module adc_trig_checker #(
   parameter int CHAN_W = 5,
   parameter int DATA_W = 8,
   parameter int RES_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              conv_start,
   input logic [CHAN_W-1:0] conv_chan,
   input logic              conv_done,
   input logic [RES_W-1:0]  conv_result,
   input logic [RES_W-1:0]  data_out,
   input logic              conv_active,
   input logic              trig_sel
);
   logic wr1;
   assign wr1 = reg_wr && !reg_addr;

   assert_start_sets_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> conv_active);

   assert_off_code_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (&conv_chan) |-> !conv_active);

   assert_done_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_active && conv_done && !wr1) |=> (!conv_active && data_out == $past(conv_result)));

   assert_idle_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_active |=> $stable(data_out));

   assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_active && !wr1) |=> !conv_start);

   assert_hw_write_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && trig_sel) |=> !conv_start);

   assert_off_write_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && (&reg_wdata[CHAN_W-1:0])) |=> (!conv_active && !conv_start));

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr |-> (reg_rdata[5:0] == 6'd0));
endmodule

bind adc_trig_ctrl adc_trig_checker #(.CHAN_W(CHAN_W), .DATA_W(DATA_W), .RES_W(RES_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
   .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
   .data_out(data_out), .conv_active(conv_active), .trig_sel(trig_sel)
);

// File: tb/adc_trig_ctrl_test.sv
`timescale 1ns/100ps
module adc_trig_ctrl_test;
   localparam int LAT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       hw_trig = 1'b0;
   logic       conv_start;
   logic [4:0] conv_chan;
   logic       conv_done = 1'b0;
   logic [9:0] conv_result = 10'h000;
   logic [9:0] data_out;

   int errors = 0, checks = 0, starts = 0, cnt = 0;
   bit model_on = 1'b1;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   adc_trig_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_result(conv_result), .data_out(data_out)
   );

   function automatic int fres(input int c);
      return (c * 37 + 11) % 1024;
   endfunction

   // converter model: done pulse LAT cycles after each start
   initial forever begin
      @(negedge clk);
      if (conv_start) starts++;
      if (!model_on) begin
         cnt = 0;
      end else begin
         conv_done = 1'b0;
         if (conv_start) begin
            cnt = LAT;
         end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               conv_done   = 1'b1;
               conv_result = 10'(fres(int'(conv_chan)));
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic a, output int v);
      reg_addr = a;
      #0.5;
      v = int'(reg_rdata);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int v;
      for (int i = 0; i < 30; i++) begin
         rd(1'b1, v);
         if (!v[7]) break;
         @(negedge clk);
      end
   endtask

   task automatic manual_done(input logic [9:0] r);
      conv_done = 1'b1; conv_result = r;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   initial begin
      #750000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v, s0;
      logic [9:0] keep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1'b0, v); check("R1 chan reset", v, 8'h1F);
      rd(1'b1, v); check("R1 trig reset", v, 8'h00);
      check("R1 data reset", int'(data_out), 0);
      check("R1 start reset", int'(conv_start), 0);

      // R2 / R3 register layout
      wr(1'b1, 8'h43); rd(1'b1, v); check("R2 hard select, reserved 0", v, 8'h40);
      wr(1'b1, 8'h3F); rd(1'b1, v); check("R2 soft select, reserved 0", v, 8'h00);
      wr(1'b1, 8'h80); rd(1'b1, v); check("R3 active not writable", v, 8'h00);

      // R4 R10 R11 software sweep over all codes except disable
      for (int c = 0; c < 31; c++) begin
         wr(1'b0, 8'(c));
         check("R4 start pulse", int'(conv_start), 1);
         check("R4 chan out", int'(conv_chan), c);
         rd(1'b0, v); check("R11 chan readback", v, c);
         rd(1'b1, v); check("R3 active set", v, 8'h80);
         wait_idle();
         rd(1'b1, v); check("R7 active cleared", v, 8'h00);
         check(c >= 29 ? "R10 reference result" : "R7 result", int'(data_out), fres(c));
      end

      // R3 trigger write during conversion keeps flag
      wr(1'b0, 8'd2);
      wr(1'b1, 8'h00);
      rd(1'b1, v); check("R3 flag survives write", v, 8'h80);
      wait_idle();

      // R7 done while idle is ignored
      model_on = 1'b0;
      @(negedge clk);
      keep = data_out;
      manual_done(10'h155);
      check("R7 idle done ignored", int'(data_out), int'(keep));

      // R8 abort and restart (model reset by new start)
      model_on = 1'b1;
      @(negedge clk);
      s0 = starts;
      wr(1'b0, 8'd3);
      @(negedge clk);
      wr(1'b0, 8'd9);
      check("R8 restart pulse", int'(conv_start), 1);
      check("R8 restart chan", int'(conv_chan), 9);
      wait_idle();
      check("R8 restart result", int'(data_out), fres(9));
      check("R8 two starts", starts - s0, 2);

      // R8 done in same cycle as channel write is discarded
      model_on = 1'b0;
      @(negedge clk);
      wr(1'b0, 8'd4);
      conv_done = 1'b1; conv_result = 10'h2AA;
      wr(1'b0, 8'd5);
      conv_done = 1'b0;
      rd(1'b1, v); check("R8 collision still active", v, 8'h80);
      check("R8 collision result dropped", int'(data_out), fres(9));
      manual_done(10'h0F0);
      check("R7 manual result", int'(data_out), 10'h0F0);
      rd(1'b1, v); check("R7 manual clear", v, 8'h00);

      // R9 disable code aborts; stray done later ignored
      model_on = 1'b1;
      @(negedge clk);
      wr(1'b0, 8'd6);
      wr(1'b0, 8'h1F);
      check("R9 no start", int'(conv_start), 0);
      rd(1'b1, v); check("R9 abort", v, 8'h00);
      check("R9 chan out", int'(conv_chan), 5'h1F);
      repeat (10) @(negedge clk);
      check("R9 stray done ignored", int'(data_out), 10'h0F0);

      // R5 hardware mode
      wr(1'b1, 8'h40);
      s0 = starts;
      wr(1'b0, 8'd7);
      check("R5 write no start", int'(conv_start), 0);
      rd(1'b1, v); check("R5 idle after write", v, 8'h40);
      hw_trig = 1'b1;
      @(negedge clk);
      check("R5 rise starts", int'(conv_start), 1);
      rd(1'b1, v); check("R5 active", v, 8'hC0);
      wait_idle();
      check("R5 result", int'(data_out), fres(7));
      repeat (10) @(negedge clk);
      check("R5 level one start", starts - s0, 1);
      hw_trig = 1'b0;
      @(negedge clk);

      // R6 rise during active ignored
      s0 = starts;
      hw_trig = 1'b1; @(negedge clk);
      hw_trig = 1'b0; @(negedge clk);
      hw_trig = 1'b1; @(negedge clk);
      hw_trig = 1'b0;
      wait_idle();
      repeat (8) @(negedge clk);
      check("R6 active rise ignored", starts - s0, 1);

      // R5 hardware-mode write aborts without restart
      wr(1'b0, 8'd12);
      hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
      wr(1'b0, 8'd13);
      check("R5 abort no start", int'(conv_start), 0);
      rd(1'b1, v); check("R8 hw abort", v, 8'h40);
      repeat (8) @(negedge clk);

      // hardware sweep over every code, disable included
      for (int c = 0; c < 32; c++) begin
         s0 = starts;
         wr(1'b0, 8'(c));
         hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
         if (c == 31) begin
            check("R6 disabled rise ignored", int'(conv_start), 0);
            rd(1'b1, v); check("R6 disabled idle", v, 8'h40);
         end else begin
            check(c >= 29 ? "R10 hw reference start" : "R5 hw start", int'(conv_start), 1);
            wait_idle();
            check("R5 hw result", int'(data_out), fres(c));
         end
         @(negedge clk);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule